// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes 32-bit commands from a three-wire link: a serial data line, a serial clock and an active-low frame enable. It never uses the serial clock or the enable as a clock. The block passes all three wires through two-flop synchronizers into the local system clock domain. It then finds their edges there and drives a small state machine from those edge events.

A frame opens when the enable falls. While the enable stays low, each rising edge of the serial clock shifts in one data bit, most significant bit first, and a bit counter advances. When the enable rises again, the frame is closed and its length is checked. Exactly 32 bits commit the word to the command output and raise a one-cycle valid pulse. Any other length raises a one-cycle error pulse, and the command output keeps its earlier value. Serial clock activity while the enable is high has no effect.

The state machine has three states. `ST_IDLE` waits for a frame to open. `ST_SHIFT` collects bits. `ST_CLOSE` is a single cycle that judges the length and then commits or rejects the word. Its transitions are:
- `ST_IDLE` to `ST_SHIFT` on an enable fall. This clears the counter and the shift register.
- `ST_SHIFT` to `ST_CLOSE` on an enable rise.
- `ST_CLOSE` to `ST_IDLE` otherwise, or `ST_CLOSE` to `ST_SHIFT` when a new enable fall arrives in that same cycle.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `cmd_o` is 0 and `cmd_valid_o` and `frame_err_o` are both 0.
- R2: In a frame of exactly 32 bits, the first bit received lands in `cmd_o[31]` and the last bit lands in `cmd_o[0]` after the commit.
- R3: `cmd_o` changes only after the enable rises. After all 32 bits have arrived but while the enable is still low, `cmd_o` still shows the previous command.
- R4: Each accepted frame produces exactly one `cmd_valid_o` pulse, one system clock cycle wide, within 8 cycles of the enable rise.
- R5: A frame holding fewer than 32 bits, including zero bits, produces one `frame_err_o` pulse one cycle wide, no valid pulse, and leaves `cmd_o` unchanged.
- R6: A frame holding more than 32 bits produces one `frame_err_o` pulse and no valid pulse, and leaves `cmd_o` unchanged. This holds even past 63 bits: the bit counter saturates and never wraps back to 32.
- R7: Serial clock pulses while the enable is high produce no pulse on either output, leave `cmd_o` unchanged, and do not disturb the next frame.
- R8: `cmd_valid_o` and `frame_err_o` are never high in the same cycle.
- R9: `cmd_o` holds its value in every cycle in which `cmd_valid_o` is not asserted.
- R10: A serial clock whose high and low phases each last at least 2 system clock cycles is received correctly. At 100 MHz this covers a 20 MHz link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to `clk` |
| ser_dat_i | input | 1 | Serial data, valid around the serial clock rising edge |
| ser_en_n_i | input | 1 | Frame enable, active low, asynchronous |
| cmd_o | output | 32 | Last accepted command |
| cmd_valid_o | output | 1 | One-cycle pulse when `cmd_o` takes a new command |
| frame_err_o | output | 1 | One-cycle pulse when a frame of the wrong length is rejected |

## Verification
The hardest case to reach is a frame whose bit count wraps a naive counter back to 32. The stimulus reaches it by sending frames of 64 to 70 bits, which should be rejected. Random serial phase widths of 2 to 4 system cycles push the edges near the lower limit of the oversampling ratio. Runs of stray serial clocks are placed while the enable is high, right before a frame, to confirm that they neither count nor shift into the next word. A check with the enable still low after the 32nd bit confirms that nothing commits before the enable rises.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Frame receiver states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CLOSE = 2'd2
    } rx_state_t;

    // Lane positions inside the synchronized input bundle
    localparam int LANE_DAT = 0;
    localparam int LANE_CLK = 1;
    localparam int LANE_EN  = 2;
    localparam int LANES    = 3;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= rst_val_i;
                    else     chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= rst_val_i;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/scr_edge.sv
module scr_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= rst_val_i;
        else     prev_q <= lvl_i;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_det
            assign rise_o[i] = lvl_i[i] & ~prev_q[i];
            assign fall_o[i] = ~lvl_i[i] & prev_q[i];
        end
    endgenerate

endmodule

// File: rtl/scr_frame_fsm.sv
module scr_frame_fsm
    import scr_pkg::*;
#(
    parameter int CMD_W = 32,
    parameter int CNT_W = $clog2(CMD_W + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_i,
    input  logic             sclk_rise_i,
    input  logic             en_fall_i,
    input  logic             en_rise_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             valid_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_W + 1);

    rx_state_t        state_q, state_d;
    logic [CMD_W-1:0] shift_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take_bit;
    logic             open_frame;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_fall_i) state_d = ST_SHIFT;
            ST_SHIFT: if (en_rise_i) state_d = ST_CLOSE;
            ST_CLOSE: state_d = en_fall_i ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign open_frame = en_fall_i && (state_q != ST_SHIFT);
    assign take_bit   = (state_q == ST_SHIFT) && sclk_rise_i && !en_rise_i;

    // Shift register and saturating bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (open_frame) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (take_bit) begin
            shift_q <= {shift_q[CMD_W-2:0], bit_i};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (state_q == ST_CLOSE) begin
                if (cnt_q == CNT_FULL) begin
                    cmd_o   <= shift_q;
                    valid_o <= 1'b1;
                end else begin
                    err_o <= 1'b1;
                end
            end
        end
    end

    // R8
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R3
    commit_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o || err_o) |-> $past(state_q) == ST_CLOSE);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != $past(cmd_o)) |-> valid_o);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_SAT);

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !en_fall_i) |=> $stable(cnt_q) && $stable(shift_q));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int CMD_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_en_n_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_valid_o,
    output logic             frame_err_o
);

    localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_EN;
    localparam logic [1:0]       EDGE_RST = 2'b10;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] syncd;
    logic [1:0]       rise, fall;

    assign raw[LANE_DAT] = ser_dat_i;
    assign raw[LANE_CLK] = ser_clk_i;
    assign raw[LANE_EN]  = ser_en_n_i;

    scr_sync #(.WIDTH(LANES), .STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_i   (raw),
        .rst_val_i (SYNC_RST),
        .sync_o    (syncd)
    );

    // edge lane 0: serial clock, lane 1: enable
    scr_edge #(.WIDTH(2)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     ({syncd[LANE_EN], syncd[LANE_CLK]}),
        .rst_val_i (EDGE_RST),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    scr_frame_fsm #(.CMD_W(CMD_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .bit_i       (syncd[LANE_DAT]),
        .sclk_rise_i (rise[0]),
        .en_fall_i   (fall[1]),
        .en_rise_i   (rise[1]),
        .cmd_o       (cmd_o),
        .valid_o     (cmd_valid_o),
        .err_o       (frame_err_o)
    );

endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdat = 1'b0;
    logic        sen_n = 1'b1;
    logic [31:0] cmd;
    logic        cvalid, ferr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_cmd = 32'd0;
    int vcnt, ecnt;

    always #5 clk = ~clk;

    serial_cmd_rx u_serial_cmd_rx (
        .clk         (clk),
        .rst         (rst),
        .ser_clk_i   (sclk),
        .ser_dat_i   (sdat),
        .ser_en_n_i  (sen_n),
        .cmd_o       (cmd),
        .cmd_valid_o (cvalid),
        .frame_err_o (ferr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] expect_after(input int len, input logic [31:0] word, input logic [31:0] prev);
        return (len == 32) ? word : prev;
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input int n);
        vcnt = 0; ecnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (cvalid) vcnt++;
            if (ferr) ecnt++;
        end
    endtask

    task automatic stray_clocks(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            sdat = 1'($urandom);
            wait_clks(half); sclk = 1'b1;
            wait_clks(half); sclk = 1'b0;
        end
        watch(8);
        // R7
        check(vcnt == 0 && ecnt == 0, "R7 no pulse on idle clocks", 32'(vcnt + ecnt), 32'd0);
        check(cmd == exp_cmd, "R7 cmd unchanged by idle clocks", cmd, exp_cmd);
    endtask

    task automatic send_frame(input logic [31:0] word, input int len, input int half, input bit mid_check);
        sen_n = 1'b0;
        wait_clks(3);
        for (int i = 0; i < len; i++) begin
            sdat = (i < 32) ? word[31-i] : 1'($urandom);
            wait_clks(half); sclk = 1'b1;
            wait_clks(half); sclk = 1'b0;
        end
        wait_clks(6);
        if (mid_check)
            // R3
            check(cmd == exp_cmd && !cvalid, "R3 no commit before enable rise", cmd, exp_cmd);
        sen_n = 1'b1;
        watch(10);
        if (len == 32) begin
            // R4 R2 R10
            check(vcnt == 1 && ecnt == 0, "R4 single valid pulse", 32'(vcnt), 32'd1);
            check(cmd == word, "R2 word MSB first", cmd, word);
        end else begin
            // R5 R6
            check(ecnt == 1 && vcnt == 0, len < 32 ? "R5 short frame error" : "R6 long frame error",
                  32'(ecnt), 32'd1);
            check(cmd == exp_cmd, len < 32 ? "R5 cmd kept" : "R6 cmd kept", cmd, exp_cmd);
        end
        exp_cmd = expect_after(len, word, exp_cmd);
        wait_clks(3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        wait_clks(5);
        // R1
        check(cmd == 32'd0 && !cvalid && !ferr, "R1 reset state", {cmd[31:2], cvalid, ferr}, 32'd0);
        rst = 1'b0;
        wait_clks(1);
        check(cmd == 32'd0 && !cvalid && !ferr, "R1 after release", cmd, 32'd0);

        // directed corner cases
        send_frame(32'h8000_0001, 32, 2, 1'b1);        // R2 R10 fastest phases
        send_frame(32'hA5C3_0F96, 32, 3, 1'b1);
        send_frame(32'h1234_5678, 0, 2, 1'b0);         // R5 empty frame
        send_frame(32'hFFFF_FFFF, 31, 2, 1'b0);        // R5
        send_frame(32'h0BAD_F00D, 33, 2, 1'b0);        // R6
        send_frame(32'hDEAD_BEEF, 64, 2, 1'b0);        // R6 counter wrap
        send_frame(32'hCAFE_0000, 70, 2, 1'b0);        // R6
        stray_clocks(5, 2);                            // R7
        send_frame(32'h7E57_0001, 32, 2, 1'b1);        // R7 next frame clean

        // constrained random
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            int sel, len, half;
            w    = $urandom;
            sel  = $urandom % 8;
            half = 2 + ($urandom % 3);
            if (sel < 5)       len = 32;
            else if (sel == 5) len = $urandom % 32;
            else if (sel == 6) len = 33 + ($urandom % 8);
            else               len = 64 + ($urandom % 7);
            if (($urandom % 4) == 0) stray_clocks(1 + ($urandom % 6), half);
            send_frame(w, len, half, (k % 5) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule